// File: doc/BRIEF.md
# Gardner Symbol Timing Recovery Loop

This block recovers symbol timing from a receive stream that is sampled twice per symbol. Every strobed sample alternates between a symbol-instant sample and a mid-symbol sample. At each symbol instant, a Gardner-style detector forms a timing error from the mid sample and the two symbol samples around it. A first-order smoothing stage filters that error, and a proportional-integral stage turns it into a control value.

The control value has two uses, picked by a role input. In master role it moves a fine receive-phase index. The index has 48 positions per symbol period, each 7.5 degrees, and advances or retreats by one position whenever the accumulated correction crosses a step threshold. In slave role it sets an 8-bit duty word for the tune input of an external oscillator, and the phase index stays where it is. A lock flag shows that the filtered error has stayed small for a long, unbroken run of symbols.

Top module: `gardner_timing_loop`

## Requirements
- R1: While reset is asserted, and right after it is released, phase_o is 0, pwm_o is 128 and lock_o is 0.
- R2: The first strobed sample after reset is a symbol sample, and strobed samples then alternate symbol, mid, symbol, mid. At every symbol sample after the first, the error is mid × (previous symbol − current symbol) in signed arithmetic, saturated to ±32767.
- R3: For each error, the smoothed value f becomes f + ((error − f) >>> 4), using an arithmetic shift.
- R4: After f is updated, the integrator becomes integ + (f >>> 6), saturated to ±524287. The control value is (f >>> 2) + integ.
- R5: In master role (role_i = 0), each control value is added to a correction accumulator that saturates at ±8388607. If the sum is 4096 or more, 4096 is subtracted and phase_o rises by one. If the sum is −4096 or less, 4096 is added and phase_o falls by one. At most one step happens per symbol.
- R6: phase_o counts modulo 48. It goes from 47 to 0 on an upward step and from 0 to 47 on a downward step.
- R7: In slave role (role_i = 1), each symbol update sets pwm_o to 128 + (control >>> 10), clamped to the range 0 to 255. phase_o and the accumulator are held.
- R8: In master role, each symbol update sets pwm_o to 128.
- R9: lock_o is 1 once 1024 consecutive symbol updates have |f| < lock_thr_i, using the updated f. One update with |f| ≥ lock_thr_i clears it.
- R10: A symbol sample taken at clock edge k changes the outputs after edge k+2. Without a strobe, the outputs do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| smp_vld_i | input | 1 | Sample strobe |
| smp_i | input | 10 | Signed two's-complement sample |
| role_i | input | 1 | 0: master (phase stepping), 1: slave (oscillator duty word) |
| lock_thr_i | input | 16 | Unsigned threshold on the magnitude of the smoothed error |
| phase_o | output | 6 | Receive phase index, 0 to 47 |
| pwm_o | output | 8 | Oscillator tune duty word |
| lock_o | output | 1 | Lock indication |

## Verification
The hardest conditions to reach from the ports are the two wraps of the phase index and the two clamps of the duty word. Reaching them takes a long, one-sided push on the integrator, followed by an unwind of the saturated accumulator. The bench builds alternating-sign symbol streams and places each mid sample with a chosen sign relative to the transition that follows it. This drives the error steadily in one direction for hundreds of symbols and then reverses it. The lock boundary is reached by sending exactly 1024 quiet symbols after reset (1023 updates) and then one more.

// File: rtl/gtl_pkg.sv
package gtl_pkg;
  typedef enum logic {SLOT_SYM = 1'b0, SLOT_MID = 1'b1} slot_e;
  typedef enum logic {ROLE_MASTER = 1'b0, ROLE_SLAVE = 1'b1} role_e;
endpackage

// File: rtl/gtl_ted.sv
module gtl_ted
  import gtl_pkg::*;
#(
  parameter int SAMPLE_W = 10,
  parameter int ERR_W    = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       smp_vld,
  input  logic signed [SAMPLE_W-1:0] smp,
  output logic                       err_vld,
  output logic signed [ERR_W-1:0]    err
);
  localparam int PROD_W = 2*SAMPLE_W + 1;
  localparam logic signed [PROD_W-1:0] EMAX = PROD_W'((1 << (ERR_W-1)) - 1);

  slot_e                      slot_q, slot_d;
  logic                       primed_q, primed_d;
  logic signed [SAMPLE_W-1:0] prev_q, prev_d, mid_q, mid_d;
  logic signed [ERR_W-1:0]    err_q, err_d;
  logic                       vld_q, vld_d;
  logic signed [SAMPLE_W:0]   diff;
  logic signed [PROD_W-1:0]   mid_x, diff_x, prod;
  logic signed [ERR_W-1:0]    prod_sat;

  always_comb begin
    diff   = $signed({prev_q[SAMPLE_W-1], prev_q}) - $signed({smp[SAMPLE_W-1], smp});
    mid_x  = PROD_W'(mid_q);
    diff_x = PROD_W'(diff);
    prod   = mid_x * diff_x;
    if (prod > EMAX)       prod_sat = ERR_W'(EMAX);
    else if (prod < -EMAX) prod_sat = ERR_W'(-EMAX);
    else                   prod_sat = ERR_W'(prod);
  end

  always_comb begin
    slot_d   = slot_q;
    primed_d = primed_q;
    prev_d   = prev_q;
    mid_d    = mid_q;
    err_d    = err_q;
    vld_d    = 1'b0;
    if (smp_vld) begin
      if (slot_q == SLOT_SYM) begin
        if (primed_q) begin
          err_d = prod_sat;
          vld_d = 1'b1;
        end
        prev_d   = smp;
        primed_d = 1'b1;
        slot_d   = SLOT_MID;
      end else begin
        mid_d  = smp;
        slot_d = SLOT_SYM;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q   <= SLOT_SYM;
      primed_q <= 1'b0;
      prev_q   <= '0;
      mid_q    <= '0;
      err_q    <= '0;
      vld_q    <= 1'b0;
    end else begin
      slot_q   <= slot_d;
      primed_q <= primed_d;
      prev_q   <= prev_d;
      mid_q    <= mid_d;
      err_q    <= err_d;
      vld_q    <= vld_d;
    end
  end

  assign err_vld = vld_q;
  assign err     = err_q;

  // R2: an error follows a symbol sample, so the slot has moved on to mid
  a_r2_err_after_sym: assert property (@(posedge clk) disable iff (!rst_n)
    err_vld |-> (slot_q == SLOT_MID));
  // R2: saturation is symmetric, so the most negative code never appears
  a_r2_sat_symmetric: assert property (@(posedge clk) disable iff (!rst_n)
    err_vld |-> (err != {1'b1, {(ERR_W-1){1'b0}}}));
endmodule

// File: rtl/gtl_loop_filter.sv
module gtl_loop_filter #(
  parameter int ERR_W     = 16,
  parameter int INT_W     = 20,
  parameter int CTRL_W    = 21,
  parameter int LPF_SHIFT = 4,
  parameter int KP_SHIFT  = 2,
  parameter int KI_SHIFT  = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     err_vld,
  input  logic signed [ERR_W-1:0]  err,
  output logic                     filt_vld,
  output logic signed [ERR_W-1:0]  filt,
  output logic signed [CTRL_W-1:0] ctrl
);
  localparam logic signed [INT_W:0] IMAX = (INT_W+1)'((1 << (INT_W-1)) - 1);

  logic signed [ERR_W-1:0] f_q, f_d;
  logic signed [INT_W-1:0] i_q, i_d;
  logic                    v_q;
  logic signed [ERR_W:0]   dlt, f_new;
  logic signed [INT_W:0]   isum;

  always_comb begin
    dlt   = $signed({err[ERR_W-1], err}) - $signed({f_q[ERR_W-1], f_q});
    f_new = $signed({f_q[ERR_W-1], f_q}) + (dlt >>> LPF_SHIFT);
    f_d   = err_vld ? f_new[ERR_W-1:0] : f_q;
    isum  = $signed({i_q[INT_W-1], i_q}) + (INT_W+1)'(f_d >>> KI_SHIFT);
    if (!err_vld)          i_d = i_q;
    else if (isum > IMAX)  i_d = INT_W'(IMAX);
    else if (isum < -IMAX) i_d = INT_W'(-IMAX);
    else                   i_d = INT_W'(isum);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_q <= '0;
      i_q <= '0;
      v_q <= 1'b0;
    end else begin
      f_q <= f_d;
      i_q <= i_d;
      v_q <= err_vld;
    end
  end

  assign filt_vld = v_q;
  assign filt     = f_q;
  assign ctrl     = CTRL_W'(f_q >>> KP_SHIFT) + CTRL_W'(i_q);

  // R4: integrator stays inside its symmetric saturation bounds
  a_r4_int_bound: assert property (@(posedge clk) disable iff (!rst_n)
    filt_vld |-> ((INT_W+1)'(i_q) <= IMAX && (INT_W+1)'(i_q) >= -IMAX));
  // R3: the smoothed value only moves on an error update
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !err_vld |=> $stable(f_q));
endmodule

// File: rtl/gtl_phase_stepper.sv
module gtl_phase_stepper
  import gtl_pkg::*;
#(
  parameter int PHASES    = 48,
  parameter int CTRL_W    = 21,
  parameter int ACC_W     = 24,
  parameter int STEP_TH   = 4096,
  parameter int PWM_W     = 8,
  parameter int PWM_SHIFT = 10
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       filt_vld,
  input  role_e                      role,
  input  logic signed [CTRL_W-1:0]   ctrl,
  output logic [$clog2(PHASES)-1:0]  phase,
  output logic [PWM_W-1:0]           pwm
);
  localparam int PH_W = $clog2(PHASES);
  localparam logic signed [ACC_W:0]   AMAX = (ACC_W+1)'((1 << (ACC_W-1)) - 1);
  localparam logic signed [ACC_W-1:0] TH   = ACC_W'(STEP_TH);
  localparam logic signed [CTRL_W:0]  PMID = (CTRL_W+1)'(1 << (PWM_W-1));
  localparam logic signed [CTRL_W:0]  PMAX = (CTRL_W+1)'((1 << PWM_W) - 1);
  localparam logic [PH_W-1:0]         LAST = PH_W'(PHASES - 1);

  logic signed [ACC_W-1:0] acc_q, acc_d, acc_s;
  logic [PH_W-1:0]         ph_q, ph_d;
  logic [PWM_W-1:0]        pwm_q, pwm_d;
  logic signed [ACC_W:0]   asum;
  logic signed [CTRL_W:0]  pv;

  always_comb begin
    asum = $signed({acc_q[ACC_W-1], acc_q}) + (ACC_W+1)'(ctrl);
    if (asum > AMAX)       acc_s = ACC_W'(AMAX);
    else if (asum < -AMAX) acc_s = ACC_W'(-AMAX);
    else                   acc_s = ACC_W'(asum);
    pv = PMID + (CTRL_W+1)'(ctrl >>> PWM_SHIFT);

    acc_d = acc_q;
    ph_d  = ph_q;
    pwm_d = pwm_q;
    if (filt_vld) begin
      if (role == ROLE_SLAVE) begin
        if (pv < 0)         pwm_d = '0;
        else if (pv > PMAX) pwm_d = '1;
        else                pwm_d = pv[PWM_W-1:0];
      end else begin
        pwm_d = PMID[PWM_W-1:0];
        acc_d = acc_s;
        if (acc_s >= TH) begin
          acc_d = acc_s - TH;
          ph_d  = (ph_q == LAST) ? '0 : ph_q + 1'b1;
        end else if (acc_s <= -TH) begin
          acc_d = acc_s + TH;
          ph_d  = (ph_q == '0) ? LAST : ph_q - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      ph_q  <= '0;
      pwm_q <= PMID[PWM_W-1:0];
    end else begin
      acc_q <= acc_d;
      ph_q  <= ph_d;
      pwm_q <= pwm_d;
    end
  end

  assign phase = ph_q;
  assign pwm   = pwm_q;

  // R5 R6: the index moves by one position, wrapping modulo PHASES
  a_r5_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != $past(ph_q)) |-> ((ph_q == $past(ph_q) + 1'b1) || (ph_q + 1'b1 == $past(ph_q))
      || ($past(ph_q) == LAST && ph_q == '0) || ($past(ph_q) == '0 && ph_q == LAST)));
  // R7: slave updates leave the phase index alone
  a_r7_hold_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_vld && role == ROLE_SLAVE) |=> $stable(ph_q));
  // R8: master updates park the duty word at mid-scale
  a_r8_mid_pwm: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_vld && role == ROLE_MASTER) |=> (pwm_q == PMID[PWM_W-1:0]));
  // R10: nothing moves without a filter update
  a_r10_no_update: assert property (@(posedge clk) disable iff (!rst_n)
    !filt_vld |=> ($stable(ph_q) && $stable(pwm_q)));
endmodule

// File: rtl/gtl_lock_detect.sv
module gtl_lock_detect #(
  parameter int ERR_W     = 16,
  parameter int LOCK_SYMS = 1024
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    filt_vld,
  input  logic signed [ERR_W-1:0] filt,
  input  logic [ERR_W-1:0]        thr,
  output logic                    lock
);
  localparam int CNT_W = $clog2(LOCK_SYMS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(LOCK_SYMS);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [ERR_W-1:0] mag;
  logic             below;

  always_comb begin
    mag   = filt[ERR_W-1] ? $unsigned(-filt) : $unsigned(filt);
    below = (mag < thr);
    cnt_d = cnt_q;
    if (filt_vld) begin
      if (!below)             cnt_d = '0;
      else if (cnt_q != FULL) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign lock = (cnt_q == FULL);

  // R9: a large filtered error drops lock on the next cycle
  a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (filt_vld && !below) |=> !lock);
  // R9: lock can only rise on a filter update
  a_r9_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(filt_vld));
endmodule

// File: rtl/gardner_timing_loop.sv
module gardner_timing_loop
  import gtl_pkg::*;
#(
  parameter int SAMPLE_W  = 10,
  parameter int ERR_W     = 16,
  parameter int INT_W     = 20,
  parameter int ACC_W     = 24,
  parameter int PHASES    = 48,
  parameter int PWM_W     = 8,
  parameter int LPF_SHIFT = 4,
  parameter int KP_SHIFT  = 2,
  parameter int KI_SHIFT  = 6,
  parameter int PWM_SHIFT = 10,
  parameter int STEP_TH   = 4096,
  parameter int LOCK_SYMS = 1024
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       smp_vld_i,
  input  logic [SAMPLE_W-1:0]        smp_i,
  input  logic                       role_i,
  input  logic [ERR_W-1:0]           lock_thr_i,
  output logic [$clog2(PHASES)-1:0]  phase_o,
  output logic [PWM_W-1:0]           pwm_o,
  output logic                       lock_o
);
  localparam int CTRL_W = INT_W + 1;

  logic [1:0]               rst_sync_q;
  logic                     rst_n;
  logic                     err_vld, filt_vld;
  logic signed [ERR_W-1:0]  err, filt;
  logic signed [CTRL_W-1:0] ctrl;
  role_e                    role;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];
  assign role  = role_e'(role_i);

  gtl_ted #(.SAMPLE_W(SAMPLE_W), .ERR_W(ERR_W)) u_ted (
    .clk(clk_i), .rst_n(rst_n), .smp_vld(smp_vld_i), .smp($signed(smp_i)),
    .err_vld(err_vld), .err(err));

  gtl_loop_filter #(.ERR_W(ERR_W), .INT_W(INT_W), .CTRL_W(CTRL_W),
    .LPF_SHIFT(LPF_SHIFT), .KP_SHIFT(KP_SHIFT), .KI_SHIFT(KI_SHIFT)) u_filt (
    .clk(clk_i), .rst_n(rst_n), .err_vld(err_vld), .err(err),
    .filt_vld(filt_vld), .filt(filt), .ctrl(ctrl));

  gtl_phase_stepper #(.PHASES(PHASES), .CTRL_W(CTRL_W), .ACC_W(ACC_W),
    .STEP_TH(STEP_TH), .PWM_W(PWM_W), .PWM_SHIFT(PWM_SHIFT)) u_step (
    .clk(clk_i), .rst_n(rst_n), .filt_vld(filt_vld), .role(role), .ctrl(ctrl),
    .phase(phase_o), .pwm(pwm_o));

  gtl_lock_detect #(.ERR_W(ERR_W), .LOCK_SYMS(LOCK_SYMS)) u_lock (
    .clk(clk_i), .rst_n(rst_n), .filt_vld(filt_vld), .filt(filt),
    .thr(lock_thr_i), .lock(lock_o));
endmodule

// File: tb/gardner_timing_loop_tb_top.sv
module gardner_timing_loop_tb_top;
  localparam int EMAX = 32767;
  localparam int IMAX = 524287;
  localparam int AMAX = 8388607;
  localparam int TH   = 4096;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       smp_vld_i = 1'b0;
  logic [9:0] smp_i = '0;
  logic       role_i = 1'b0;
  logic [15:0] lock_thr_i = 16'd100;
  logic [5:0] phase_o;
  logic [7:0] pwm_o;
  logic       lock_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  bit done = 0, cmp_en = 0;
  bit seen_up_wrap = 0, seen_dn_wrap = 0, seen_pwm_hi = 0, seen_pwm_lo = 0;
  int last_ph = 0;

  // behavioural reference state
  int m_slot, m_primed, m_prev, m_mid, m_ev, m_e, m_fv, m_f, m_int, m_acc, m_ph, m_pwm, m_cnt;

  always #2.5 clk_i = ~clk_i;

  gardner_timing_loop dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_vld_i(smp_vld_i), .smp_i(smp_i),
    .role_i(role_i), .lock_thr_i(lock_thr_i), .phase_o(phase_o), .pwm_o(pwm_o),
    .lock_o(lock_o));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic int clampi(input int v, input int lo, input int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  // reference model: later stages first, so each reads last cycle's values
  always @(posedge clk_i) begin
    int c, a, s, mag;
    cyc++;
    if (!rst_ni) begin
      m_slot = 0; m_primed = 0; m_prev = 0; m_mid = 0; m_ev = 0; m_e = 0;
      m_fv = 0; m_f = 0; m_int = 0; m_acc = 0; m_ph = 0; m_pwm = 128; m_cnt = 0;
    end else begin
      if (m_fv != 0) begin
        c = (m_f >>> 2) + m_int;                       // R4
        if (role_i) m_pwm = clampi(128 + (c >>> 10), 0, 255);   // R7
        else begin
          m_pwm = 128;                                 // R8
          a = clampi(m_acc + c, -AMAX, AMAX);          // R5
          if (a >= TH) begin a -= TH; m_ph = (m_ph + 1) % 48; end
          else if (a <= -TH) begin a += TH; m_ph = (m_ph + 47) % 48; end
          m_acc = a;
        end
        mag = (m_f < 0) ? -m_f : m_f;                  // R9
        if (mag < int'(lock_thr_i)) m_cnt = (m_cnt < 1024) ? m_cnt + 1 : 1024;
        else m_cnt = 0;
      end
      m_fv = m_ev;
      if (m_ev != 0) begin
        m_f = m_f + ((m_e - m_f) >>> 4);               // R3
        s = m_int + (m_f >>> 6);
        m_int = clampi(s, -IMAX, IMAX);
      end
      m_ev = 0;
      if (smp_vld_i) begin                             // R2
        s = int'($signed(smp_i));
        if (m_slot == 0) begin
          if (m_primed != 0) begin
            m_e = clampi(m_mid * (m_prev - s), -EMAX, EMAX);
            m_ev = 1;
          end
          m_prev = s; m_primed = 1; m_slot = 1;
        end else begin
          m_mid = s; m_slot = 0;
        end
      end
    end
  end

  // compare every cycle away from the active edge (R10 latency via the model)
  always @(negedge clk_i) begin
    if (cmp_en) begin
      chk(int'(phase_o) == m_ph, "R5 phase_o (path R2 R3 R4 R10)", phase_o, m_ph);
      chk(int'(pwm_o) == m_pwm, "R7 pwm_o (path R8 R10)", pwm_o, m_pwm);
      chk(lock_o == (m_cnt == 1024), "R9 lock_o", lock_o, (m_cnt == 1024));
      if (last_ph == 47 && phase_o == 0) seen_up_wrap = 1;
      if (last_ph == 0 && phase_o == 47) seen_dn_wrap = 1;
      if (pwm_o == 8'd255) seen_pwm_hi = 1;
      if (pwm_o == 8'd0) seen_pwm_lo = 1;
      last_ph = phase_o;
    end
  end

  always @(posedge clk_i) begin
    if (cyc > 190000 && !done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=<190000 cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic send_pair(input int sym, input int mid);
    @(negedge clk_i); smp_vld_i = 1'b1; smp_i = 10'(sym);
    @(negedge clk_i); smp_vld_i = 1'b0;
    @(negedge clk_i); smp_vld_i = 1'b1; smp_i = 10'(mid);
    @(negedge clk_i); smp_vld_i = 1'b0;
  endtask

  // alternating symbols, mid placed so the error has sign dir
  task automatic push(input int n, input int dir, input int amp, input int m);
    for (int i = 0; i < n; i++) begin
      int s;
      s = (i % 2 == 0) ? amp : -amp;
      send_pair(s, dir * m * ((s > 0) ? 1 : -1));
    end
  endtask

  task automatic do_reset();
    @(negedge clk_i); rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
  endtask

  task automatic settle();
    repeat (5) @(negedge clk_i);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    cmp_en = 1;
    chk(phase_o == 0, "R1 phase_o in reset", phase_o, 0);
    chk(pwm_o == 8'd128, "R1 pwm_o in reset", pwm_o, 128);
    chk(lock_o == 1'b0, "R1 lock_o in reset", lock_o, 0);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    chk(phase_o == 0 && pwm_o == 8'd128 && !lock_o, "R1 state after release", phase_o, 0);

    // master: push up, then down, to wrap both ways (R5 R6 R8)
    role_i = 1'b0;
    push(200, 1, 300, 200);
    push(1500, -1, 300, 200);
    settle();
    chk(seen_up_wrap, "R6 upward wrap 47->0 seen", seen_up_wrap, 1);
    chk(seen_dn_wrap, "R6 downward wrap 0->47 seen", seen_dn_wrap, 1);
    chk(pwm_o == 8'd128, "R8 pwm_o parked in master", pwm_o, 128);

    // slave: duty clamps high then low, phase held (R7)
    do_reset();
    role_i = 1'b1;
    push(300, 1, 300, 200);
    settle();
    chk(seen_pwm_hi, "R7 pwm_o clamp 255 seen", seen_pwm_hi, 1);
    push(1500, -1, 300, 200);
    settle();
    chk(seen_pwm_lo, "R7 pwm_o clamp 0 seen", seen_pwm_lo, 1);
    chk(phase_o == 0, "R7 phase_o held in slave", phase_o, 0);

    // lock boundary (R9)
    do_reset();
    role_i = 1'b0; lock_thr_i = 16'd100;
    for (int i = 0; i < 1024; i++) send_pair(0, 0);
    settle();
    chk(lock_o == 1'b0, "R9 no lock after 1023 updates", lock_o, 0);
    send_pair(0, 0);
    settle();
    chk(lock_o == 1'b1, "R9 lock after 1024 updates", lock_o, 1);
    send_pair(0, 200);
    settle();
    chk(lock_o == 1'b1, "R9 lock kept on quiet update", lock_o, 1);
    send_pair(300, 0);
    settle();
    chk(lock_o == 1'b0, "R9 lock cleared by large error", lock_o, 0);

    // random full-scale samples, role toggling, saturating errors (R2 R10)
    do_reset();
    for (int i = 0; i < 600; i++) begin
      if (i % 100 == 0) begin
        role_i = ~role_i;
        lock_thr_i = 16'($urandom_range(0, 4095));
      end
      send_pair(int'($urandom_range(0, 1023)) - 512, int'($urandom_range(0, 1023)) - 512);
      if (i % 37 == 0) repeat (3) @(negedge clk_i);
    end
    settle();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule